// File: doc/BRIEF.md
# Serial Receive Channel with Selectable Error Reporting

This block is the receive half of one asynchronous serial channel. A 16x sampling enable drives a two-stage synchronizer and a deserializer. The deserializer confirms a start bit at mid-bit and collects 5 to 8 data bits, least significant bit first. It then takes an optional parity bit and a stop bit. Each finished character goes into a three-entry receive queue. Parity-error, framing-error and break flags travel with each entry.

The host pops the head entry with a one-cycle read strobe. The status flags can follow the head entry alone. They can also hold a sticky OR over every entry that has been at the head since the last error-clear strobe. An interrupt output follows either "data available" or "queue full". An active-low request-to-send output is set and cleared by host strobes. It can also be negated by the receiver itself when the queue fills.

Top module: `uart_rx_errmode`

## Requirements
- R1: While rst_ni is low, rx_ready_o, fifo_full_o, all three error flags, overrun_o, irq_o and rd_data_o are 0, and rts_no is 1.
- R2: len_sel_i selects the data length: 00=5, 01=6, 10=7, 11=8 bits. Bits arrive LSB first and unused upper bits of rd_data_o read 0. A low level is accepted as a start bit only if it is still low 8 sample ticks later. With tick_i high every cycle, the first clock edge that sees rxd_i low is called E. The entry is visible after edge E+11+16k, where k is the number of data bits, plus the parity bit, plus one.
- R3: par_mode_i selects parity: 00 or 11 = none, 01 = with parity, 10 = forced. With parity, the parity type 0 checks for an even total of ones and 1 for an odd total. Forced parity expects the parity bit to equal par_type_i. The parity flag is set when the check fails.
- R4: A low stop bit on a character that is not a break sets the framing flag.
- R5: A break is a character with every data bit, the parity bit (if present) and the stop bit low. It is stored as one entry with data 0x00, the break flag set and the other two flags clear. No new start bit is accepted until the line returns high.
- R6: The queue holds 3 entries. rx_ready_o means at least one entry is held and fifo_full_o means all 3 are held. A read strobe pops the head at the next clock edge. A read on an empty queue has no effect.
- R7: A character that completes while the queue is full, with no pop in the same cycle, is dropped and sets overrun_o. overrun_o stays set until err_clr_i.
- R8: With err_block_i=0, the three error flags show those of the head entry, and 0 when the queue is empty.
- R9: With err_block_i=1, each error flag is the OR of the head entry's flag and the same flag of every entry that was at the head at a clock edge since the last err_clr_i edge.
- R10: irq_o equals rx_ready_o when irq_full_sel_i=0 and fifo_full_o when it is 1.
- R11: At a clock edge, rts_off_i drives rts_no to 1. Otherwise rts_on_i drives it to 0. Otherwise it holds. rts_off_i wins when both are high.
- R12: With rts_auto_i=1, a full queue at a clock edge drives rts_no to 1 at that edge, overriding rts_on_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 16x sample enable |
| rxd_i | input | 1 | Serial input, idle high |
| len_sel_i | input | 2 | Data length select |
| par_mode_i | input | 2 | Parity mode |
| par_type_i | input | 1 | Parity type, or the forced parity value |
| err_block_i | input | 1 | 1 = cumulative error flags |
| irq_full_sel_i | input | 1 | 1 = interrupt on queue full |
| rts_auto_i | input | 1 | 1 = receiver may negate RTS |
| rts_on_i | input | 1 | Assert RTS strobe |
| rts_off_i | input | 1 | Negate RTS strobe |
| err_clr_i | input | 1 | Clear cumulative flags and overrun |
| rd_i | input | 1 | Pop head entry |
| rd_data_o | output | 8 | Head entry data |
| rx_ready_o | output | 1 | Queue not empty |
| fifo_full_o | output | 1 | Queue full |
| par_err_o | output | 1 | Parity error flag |
| frm_err_o | output | 1 | Framing error flag |
| brk_o | output | 1 | Break flag |
| overrun_o | output | 1 | Sticky overrun |
| irq_o | output | 1 | Interrupt request |
| rts_no | output | 1 | Request to send, active low |

## Verification
A new character changes the outputs 11+16k edges after the first edge that sees the falling start edge. The reference model schedules its push for that exact edge. Pops, overrun, the cumulative flags and rts_no take effect at the edge after their strobe or condition. The model applies them in the same edge update, using the state from before that edge. irq_o and the selected flags follow their configuration inputs combinationally. Inputs change a quarter period after each rising edge, and every output is compared with the model at each falling edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_flags_t;

  typedef struct packed {
    rx_flags_t  flags;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAIT_HI
  } rx_state_e;

  localparam logic [1:0] PAR_WITH  = 2'b01;
  localparam logic [1:0] PAR_FORCE = 2'b10;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int SYNC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] len_sel_i,
  input  logic [1:0] par_mode_i,
  input  logic       par_type_i,
  output logic       push_o,
  output rx_entry_t  entry_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] CNT_HALF = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(OVS - 1);

  logic [SYNC-1:0] sync_q;
  logic            rx_s;
  rx_state_e       state_q;
  logic [CW-1:0]   cnt_q;
  logic [2:0]      bit_q;
  logic [7:0]      data_q;
  logic            pbit_q;
  logic            push_q;
  rx_entry_t       entry_q;

  logic      par_en, is_brk, par_bad;
  logic [2:0] last_bit;
  rx_entry_t done_entry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC-2:0], rxd_i};
  end
  assign rx_s = sync_q[SYNC-1];

  assign par_en   = (par_mode_i == PAR_WITH) || (par_mode_i == PAR_FORCE);
  assign last_bit = 3'd4 + {1'b0, len_sel_i};

  // entry built from the stop-bit sample taken this edge
  always_comb begin
    is_brk  = (data_q == 8'h00) && !(par_en && pbit_q) && !rx_s;
    par_bad = 1'b0;
    if (par_mode_i == PAR_WITH)       par_bad = ((^data_q) ^ pbit_q) != par_type_i;
    else if (par_mode_i == PAR_FORCE) par_bad = pbit_q != par_type_i;
    done_entry.data      = is_brk ? 8'h00 : data_q;
    done_entry.flags.brk = is_brk;
    done_entry.flags.frm = !rx_s && !is_brk;
    done_entry.flags.par = par_en && !is_brk && par_bad;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      data_q  <= '0;
      pbit_q  <= 1'b0;
      push_q  <= 1'b0;
      entry_q <= '0;
    end else begin
      push_q <= 1'b0;
      if (tick_i) begin
        case (state_q)
          ST_IDLE: begin
            cnt_q <= '0;
            if (!rx_s) state_q <= ST_START;
          end
          ST_START: begin
            if (cnt_q == CNT_HALF) begin
              cnt_q  <= '0;
              bit_q  <= '0;
              data_q <= '0;
              pbit_q <= 1'b0;
              state_q <= rx_s ? ST_IDLE : ST_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (cnt_q == CNT_FULL) begin
              cnt_q <= '0;
              data_q[bit_q] <= rx_s;
              if (bit_q == last_bit) state_q <= par_en ? ST_PAR : ST_STOP;
              else                   bit_q   <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_PAR: begin
            if (cnt_q == CNT_FULL) begin
              cnt_q   <= '0;
              pbit_q  <= rx_s;
              state_q <= ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: begin
            if (cnt_q == CNT_FULL) begin
              cnt_q   <= '0;
              push_q  <= 1'b1;
              entry_q <= done_entry;
              state_q <= rx_s ? ST_IDLE : ST_WAIT_HI;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_WAIT_HI: if (rx_s) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign push_o  = push_q;
  assign entry_o = entry_q;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  rx_entry_t       entry_i,
  input  logic            pop_i,
  output rx_entry_t       head_o,
  output logic [CNTW-1:0] count_o,
  output logic            ovr_evt_o
);
  rx_entry_t       mem_q [DEPTH];
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] wr_idx;
  logic            do_pop, do_push;

  assign do_pop    = pop_i && (cnt_q != '0);
  assign do_push   = push_i && ((cnt_q != CNTW'(DEPTH)) || do_pop);
  assign ovr_evt_o = push_i && !do_push;
  assign wr_idx    = do_pop ? cnt_q - 1'b1 : cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rx_entry_t shift_in;
    if (i == DEPTH - 1) begin : g_last
      assign shift_in = '0;
    end else begin : g_mid
      assign shift_in = mem_q[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[i] <= '0;
      else if (do_push && wr_idx == CNTW'(i))   mem_q[i] <= entry_i;
      else if (do_pop)                          mem_q[i] <= shift_in;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (do_push && !do_pop) cnt_q <= cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
  end

  assign head_o  = (cnt_q != '0) ? mem_q[0] : '0;
  assign count_o = cnt_q;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  rx_flags_t head_flags_i,
  input  logic      block_i,
  input  logic      clr_i,
  input  logic      ovr_evt_i,
  output rx_flags_t flags_o,
  output logic      overrun_o
);
  rx_flags_t acc_q;
  logic      ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      acc_q <= clr_i ? rx_flags_t'('0) : (acc_q | head_flags_i);
      ovr_q <= (ovr_q && !clr_i) || ovr_evt_i;
    end
  end

  assign flags_o   = block_i ? (acc_q | head_flags_i) : head_flags_i;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic off_i,
  input  logic auto_i,
  input  logic full_i,
  output logic rts_no
);
  logic rts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rts_q <= 1'b1;
    else if (off_i || (auto_i && full_i)) rts_q <= 1'b1;
    else if (on_i)                      rts_q <= 1'b0;
  end

  assign rts_no = rts_q;
endmodule

// File: rtl/uart_rx_errmode.sv
module uart_rx_errmode
  import uart_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int SYNC  = 2,
  parameter int DEPTH = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] len_sel_i,
  input  logic [1:0] par_mode_i,
  input  logic       par_type_i,
  input  logic       err_block_i,
  input  logic       irq_full_sel_i,
  input  logic       rts_auto_i,
  input  logic       rts_on_i,
  input  logic       rts_off_i,
  input  logic       err_clr_i,
  input  logic       rd_i,
  output logic [7:0] rd_data_o,
  output logic       rx_ready_o,
  output logic       fifo_full_o,
  output logic       par_err_o,
  output logic       frm_err_o,
  output logic       brk_o,
  output logic       overrun_o,
  output logic       irq_o,
  output logic       rts_no
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic            push;
  rx_entry_t       new_entry, head;
  logic [CNTW-1:0] count;
  logic            ovr_evt;
  rx_flags_t       flags;

  uart_rx_deser #(.OVS(OVS), .SYNC(SYNC)) u_deser (
    .clk_i, .rst_ni, .tick_i, .rxd_i, .len_sel_i, .par_mode_i, .par_type_i,
    .push_o(push), .entry_o(new_entry)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .entry_i(new_entry), .pop_i(rd_i),
    .head_o(head), .count_o(count), .ovr_evt_o(ovr_evt)
  );

  uart_rx_status u_status (
    .clk_i, .rst_ni, .head_flags_i(head.flags), .block_i(err_block_i),
    .clr_i(err_clr_i), .ovr_evt_i(ovr_evt), .flags_o(flags), .overrun_o
  );

  assign rx_ready_o  = count != '0;
  assign fifo_full_o = count == CNTW'(DEPTH);

  uart_rx_rts u_rts (
    .clk_i, .rst_ni, .on_i(rts_on_i), .off_i(rts_off_i),
    .auto_i(rts_auto_i), .full_i(fifo_full_o), .rts_no
  );

  assign rd_data_o = head.data;
  assign par_err_o = flags.par;
  assign frm_err_o = flags.frm;
  assign brk_o     = flags.brk;
  assign irq_o     = irq_full_sel_i ? fifo_full_o : rx_ready_o;
endmodule

// File: rtl/uart_rx_errmode_chk.sv
module uart_rx_errmode_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       err_block_i,
  input logic       rts_auto_i,
  input logic       rts_on_i,
  input logic       rts_off_i,
  input logic       err_clr_i,
  input logic [7:0] rd_data_o,
  input logic       rx_ready_o,
  input logic       fifo_full_o,
  input logic       par_err_o,
  input logic       frm_err_o,
  input logic       brk_o,
  input logic       overrun_o,
  input logic       rts_no
);
  // R6
  full_implies_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_o |-> rx_ready_o);

  // R12
  auto_rts_negate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_auto_i && fifo_full_o) |=> rts_no);

  // R11
  rts_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_on_i && !rts_off_i && !(rts_auto_i && fifo_full_o)) |=> !rts_no);

  // R11
  rts_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_off_i |=> rts_no);

  // R7
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !err_clr_i) |=> overrun_o);

  // R8
  char_mode_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_block_i && !rx_ready_o) |-> !(par_err_o || frm_err_o || brk_o));

  // R5
  brk_data_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_block_i && brk_o) |-> (rd_data_o == 8'h00 && !frm_err_o && !par_err_o));

  // R9
  block_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_block_i && !err_clr_i && brk_o) |=> (!err_block_i || brk_o));
endmodule

bind uart_rx_errmode uart_rx_errmode_chk u_chk (.*);

// File: tb/tb_uart_rx_errmode.sv
module tb_uart_rx_errmode;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 150000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 1'b1, rxd = 1'b1;
  logic [1:0] len_sel = 2'b11, par_mode = 2'b00;
  logic par_type = 1'b0, err_block = 1'b0, irq_sel = 1'b0, rts_auto = 1'b0;
  logic rts_on = 1'b0, rts_off = 1'b0, err_clr = 1'b0, rd = 1'b0;

  logic [7:0] rd_data;
  logic rx_ready, fifo_full, par_err, frm_err, brk, overrun, irq, rts_n;

  uart_rx_errmode dut (
    .clk_i(clk), .rst_ni, .tick_i(tick), .rxd_i(rxd), .len_sel_i(len_sel),
    .par_mode_i(par_mode), .par_type_i(par_type), .err_block_i(err_block),
    .irq_full_sel_i(irq_sel), .rts_auto_i(rts_auto), .rts_on_i(rts_on),
    .rts_off_i(rts_off), .err_clr_i(err_clr), .rd_i(rd), .rd_data_o(rd_data),
    .rx_ready_o(rx_ready), .fifo_full_o(fifo_full), .par_err_o(par_err),
    .frm_err_o(frm_err), .brk_o(brk), .overrun_o(overrun), .irq_o(irq),
    .rts_no(rts_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  // model: entry = {brk, frm, par, data}
  logic [10:0] mq[$];
  logic [2:0]  m_acc = 3'b000;
  logic        m_ovr = 1'b0, m_rts = 1'b1;
  int          sched_cyc = -1;
  logic [10:0] sched_ent = '0;

  always @(posedge clk) begin
    logic [10:0] head;
    logic old_full, ovr_ev;
    cyc++;
    if (!rst_ni) begin
      mq.delete(); m_acc = 3'b000; m_ovr = 1'b0; m_rts = 1'b1;
    end else begin
      old_full = mq.size() == 3;
      head = (mq.size() > 0) ? mq[0] : 11'h0;
      if (rts_off || (rts_auto && old_full)) m_rts = 1'b1;
      else if (rts_on) m_rts = 1'b0;
      if (err_clr) m_acc = 3'b000; else m_acc = m_acc | head[10:8];
      ovr_ev = 1'b0;
      if (rd && mq.size() > 0) void'(mq.pop_front());
      if (cyc == sched_cyc) begin
        if (mq.size() < 3) mq.push_back(sched_ent); else ovr_ev = 1'b1;
      end
      m_ovr = (m_ovr && !err_clr) || ovr_ev;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [10:0] head;
    logic [2:0] fl;
    head = (mq.size() > 0) ? mq[0] : 11'h0;
    fl = err_block ? (m_acc | head[10:8]) : head[10:8];
    if (!rst_ni) begin
      chk("R1 ready", rx_ready, 0); chk("R1 full", fifo_full, 0);
      chk("R1 flags", {brk, frm_err, par_err}, 0); chk("R1 overrun", overrun, 0);
      chk("R1 irq", irq, 0); chk("R1 rts", rts_n, 1); chk("R1 data", rd_data, 0);
    end else if (!done) begin
      chk("R2 data", rd_data, head[7:0]);
      chk("R6 ready", rx_ready, mq.size() > 0);
      chk("R6 full", fifo_full, mq.size() == 3);
      chk(err_block ? "R3/R9 par" : "R3/R8 par", par_err, fl[0]);
      chk(err_block ? "R4/R9 frm" : "R4/R8 frm", frm_err, fl[1]);
      chk(err_block ? "R5/R9 brk" : "R5/R8 brk", brk, fl[2]);
      chk("R7 overrun", overrun, m_ovr);
      chk("R10 irq", irq, irq_sel ? (mq.size() == 3) : (mq.size() > 0));
      chk(rts_auto ? "R12 rts" : "R11 rts", rts_n, m_rts);
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
    end
  endtask

  task automatic pulse_rd();
    rd = 1'b1; step(); rd = 1'b0; step(2);
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1; step(); err_clr = 1'b0; step(2);
  endtask

  // R2 R3 R4 R5: frame generator with independently computed expectation
  task automatic send_frame(input logic [7:0] d, input bit flip_par, input logic stop);
    int nb, k;
    bit hp;
    logic [7:0] dm;
    logic pb, e_brk, e_frm, e_par;
    nb = 5 + int'(len_sel);
    hp = (par_mode == 2'b01) || (par_mode == 2'b10);
    dm = d & 8'((9'd1 << nb) - 1);
    pb = (par_mode == 2'b10) ? par_type : ((^dm) ^ par_type);
    if (flip_par) pb = ~pb;
    k = nb + int'(hp) + 1;
    e_brk = (dm == 8'h00) && !(hp && pb) && !stop;
    e_frm = !stop && !e_brk;
    e_par = hp && !e_brk && flip_par;
    sched_ent = {e_brk, e_frm, e_par, e_brk ? 8'h00 : dm};
    sched_cyc = cyc + 12 + 16 * k;
    rxd = 1'b0; step(16);
    for (int i = 0; i < nb; i++) begin rxd = dm[i]; step(16); end
    if (hp) begin rxd = pb; step(16); end
    rxd = stop; step(16);
    rxd = 1'b1;
    if (!stop) step(16);
  endtask

  initial begin
    step(5);
    rst_ni = 1'b1;
    step(20);

    // R2 short glitch rejected
    rxd = 1'b0; step(4); rxd = 1'b1; step(30);

    // R2 8 bits, no parity
    send_frame(8'hA5, 0, 1'b1); step(3); pulse_rd();
    // R6 read on empty has no effect
    pulse_rd();

    // R2 5-bit length masks upper bits
    len_sel = 2'b00; send_frame(8'hF3, 0, 1'b1); step(3); pulse_rd();
    len_sel = 2'b01; send_frame(8'h2A, 0, 1'b1); step(3); pulse_rd();

    // R3 parity variants on 7-bit characters
    len_sel = 2'b10; par_mode = 2'b01; par_type = 1'b0;
    send_frame(8'h55, 0, 1'b1); step(3); pulse_rd();
    par_type = 1'b1;
    send_frame(8'h13, 1, 1'b1); step(3); pulse_rd();
    par_mode = 2'b10; par_type = 1'b1;
    send_frame(8'h40, 1, 1'b1); step(3); pulse_rd();
    send_frame(8'h40, 0, 1'b1); step(3); pulse_rd();
    par_mode = 2'b11;
    send_frame(8'h7E, 0, 1'b1); step(3); pulse_rd();

    // R4 framing error, R5 break without and with parity
    len_sel = 2'b11; par_mode = 2'b00;
    send_frame(8'h3C, 0, 1'b0); step(3); pulse_rd();
    send_frame(8'h00, 0, 1'b0); step(40); pulse_rd();
    len_sel = 2'b10; par_mode = 2'b01; par_type = 1'b1;
    send_frame(8'h00, 1, 1'b0); step(3); pulse_rd();
    send_frame(8'h21, 0, 1'b1); step(3); pulse_rd();

    // R11 host RTS control
    len_sel = 2'b11; par_mode = 2'b00; par_type = 1'b0;
    rts_on = 1'b1; step(); rts_on = 1'b0; step(3);
    rts_on = 1'b1; rts_off = 1'b1; step(); rts_on = 1'b0; rts_off = 1'b0; step(3);
    rts_on = 1'b1; step(); rts_on = 1'b0; step(3);

    // R9 block mode, R7 overrun, R10 full irq, R12 auto RTS
    pulse_clr();
    err_block = 1'b1; irq_sel = 1'b1; rts_auto = 1'b1;
    send_frame(8'h11, 0, 1'b1);
    send_frame(8'h22, 0, 1'b0);
    par_mode = 2'b01;
    send_frame(8'h33, 1, 1'b1);
    rts_on = 1'b1; step(); rts_on = 1'b0; step(3);
    par_mode = 2'b00;
    send_frame(8'h44, 0, 1'b1); step(3);
    pulse_rd(); pulse_rd();
    irq_sel = 1'b0;
    err_block = 1'b0; step(3); err_block = 1'b1; step(3);
    pulse_clr();
    pulse_rd(); step(3);
    pulse_clr();

    // R8 char mode on same traffic
    err_block = 1'b0;
    par_mode = 2'b01;
    send_frame(8'h5A, 1, 1'b1);
    par_mode = 2'b00;
    send_frame(8'h5B, 0, 1'b1); step(3);
    pulse_rd(); pulse_rd(); step(5);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule